// File: doc/BRIEF.md
# GPIO Interrupt Detect and Status

This block is the interrupt front end of a GPIO bank. For each pin it receives an already synchronized input level together with two trigger bits: a kind bit that chooses between edge and level sensing, and a polarity bit that flips the sensed sense. A detected event sets that pin's bit in a bitmapped status word. The bits stay set until software writes ones to them. Bits that are both set in status and enabled in a matching bitmapped enable word are ORed into a single interrupt. After one register stage, that interrupt drives one of two request lines. A small control word chooses the line.

Software uses a plain word-wide register port with a byte address, a write strobe and combinational read data. Every status and enable word covers 32 pins. When the pin count is not a multiple of 32, the bits above the last pin are always zero. A clear that lands in the same cycle as a new event on the same pin loses, so no event is dropped while software is servicing an earlier one.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: With kind bit 0 and polarity bit 0, a pin's status bit is set by the clock edge at which its input is first seen high after being low. A steady high level sets nothing, including a level that was already high during reset.
- R2: With kind bit 0 and polarity bit 1, the status bit is set only when the input goes from high to low. A rising input sets nothing.
- R3: With kind bit 1 and polarity bit 0, the status bit is set on every clock edge at which the input is low. While the input stays low, a clear therefore leaves the bit set.
- R4: With kind bit 1 and polarity bit 1, the status bit is set on every clock edge at which the input is high, and never while it is low.
- R5: Status word k sits at byte address 0x80+4k and enable word k at 0x90+4k. Bit i of word k belongs to pin 32k+i. Bits above the last pin read 0, and any other address outside these words and the control word reads 0.
- R6: Writing a status word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: When a new event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R8: A status bit latches whether or not its enable bit is set. Enable masks only the combined interrupt.
- R9: The combined interrupt is the OR over all pins of status AND enable. It is registered, so it appears one clock after the status or enable bits that cause it.
- R10: Bit 0 of the control word at 0x7C selects the request line: 0 drives irq_out[0] and 1 drives irq_out[1]. The line that is not selected is held low, and the control word reads back bit 0 with all other bits 0.
- R11: After reset, all status, enable and control bits are 0 and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_level | input | NUM_PINS | Synchronized input level of each pin |
| trig_level | input | NUM_PINS | Per-pin trigger kind: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Per-pin polarity bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 2 | Interrupt request lines; only the selected one can be high |

## Verification
On every cycle, the embedded assertions check the following. A latched event is never lost to a same-cycle clear. Status bits change only through events or write-1 clears. An edge-mode event only occurs when the input has changed. The request lines lag status AND enable by exactly one clock, and at most one line is ever high. Other behaviours can only be shown by the bench's scenarios against its own reference model: which polarity each of the four trigger kinds responds to, the address map with its zero-filled upper bits, line switching, and the absence of an edge straight after reset.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the GPIO interrupt block: register addresses and the
// encoding of the two per-pin trigger bits. Assumes byte addressing, 32-bit words.
package gpio_irq_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    // Register map anchors (software decodes these)
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h7C;
    localparam logic [ADDR_W-1:0] STAT_BASE = 8'h80;
    localparam logic [ADDR_W-1:0] EN_BASE   = 8'h90;

    // {kind, polarity} pair of a pin
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_kind_e;

endpackage

// File: rtl/gpio_irq_detect.sv
// Per-pin event detector. Keeps one cycle of input history and turns each pin's
// level plus its {kind, polarity} bits into a single-cycle event pulse.
// Assumes pin_level is already synchronized to clk. The history register is
// loaded during reset too, so no edge is seen right after reset.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] trig_level,
    input  logic [NUM_PINS-1:0] trig_inv,
    output logic [NUM_PINS-1:0] pin_event
);

    logic [NUM_PINS-1:0] hist_q;

    // Input history; tracks the pins in and out of reset alike
    always_ff @(posedge clk) begin
        hist_q <= pin_level;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // Decode the trigger kind of pin i into its event condition
        always_comb begin
            unique case (trig_kind_e'({trig_level[i], trig_inv[i]}))
                TRIG_RISE: pin_event[i] =  pin_level[i] & ~hist_q[i];
                TRIG_FALL: pin_event[i] = ~pin_level[i] &  hist_q[i];
                TRIG_LOW:  pin_event[i] = ~pin_level[i];
                default:   pin_event[i] =  pin_level[i];
            endcase
        end

        AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !trig_level[i] && pin_event[i]) |-> (pin_level[i] != $past(pin_level[i])));  // R1
    end

endmodule

// File: rtl/gpio_irq_status_bank.sv
// Bitmapped status and enable storage. Status bits are set by events and
// cleared by writing ones; an event beats a clear in the same cycle. Enable
// words are plain read/write. Read data is zero outside these words.
// Assumes at most four 32-bit words so the status block stays below 0x90.
module gpio_irq_status_bank
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_event,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [REG_W-1:0]    wdata,
    output logic [NUM_PINS-1:0] status,
    output logic [NUM_PINS-1:0] enable,
    output logic [REG_W-1:0]    rdata
);

    localparam int NUM_WORDS = (NUM_PINS + REG_W - 1) / REG_W;
    localparam int PAD_W     = NUM_WORDS * REG_W;
    localparam logic [PAD_W-1:0] VALID = (PAD_W'(1) << NUM_PINS) - PAD_W'(1);

    logic [PAD_W-1:0] status_q, status_d;
    logic [PAD_W-1:0] enable_q, enable_d;
    logic [PAD_W-1:0] ev_pad;
    logic [PAD_W-1:0] clr_mask;
    logic [PAD_W-1:0] en_wmask;

    // Widen the event vector to whole words
    always_comb begin
        ev_pad = '0;
        ev_pad[NUM_PINS-1:0] = pin_event;
    end

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        localparam logic [ADDR_W-1:0] S_ADDR = STAT_BASE + ADDR_W'(4 * k);
        localparam logic [ADDR_W-1:0] E_ADDR = EN_BASE + ADDR_W'(4 * k);
        // Decode write-1-to-clear bits for status word k
        assign clr_mask[k*REG_W +: REG_W] = (wr_en && addr == S_ADDR) ? wdata : '0;
        // Decode the write strobe of enable word k
        assign en_wmask[k*REG_W +: REG_W] = {REG_W{wr_en && addr == E_ADDR}};
    end

    // Next status: clear requested ones, then let new events win
    always_comb begin
        status_d = ((status_q & ~clr_mask) | ev_pad) & VALID;
    end

    // Next enable: replace the addressed word
    always_comb begin
        enable_d = ((enable_q & ~en_wmask) | ({NUM_WORDS{wdata}} & en_wmask)) & VALID;
    end

    // Status and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= status_d;
            enable_q <= enable_d;
        end
    end

    assign status = status_q[NUM_PINS-1:0];
    assign enable = enable_q[NUM_PINS-1:0];

    // Read mux over the status and enable words
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (addr == STAT_BASE + ADDR_W'(4 * k)) rdata = status_q[k*REG_W +: REG_W];
            if (addr == EN_BASE + ADDR_W'(4 * k))   rdata = enable_q[k*REG_W +: REG_W];
        end
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & $past(ev_pad)) == $past(ev_pad)));  // R7
    AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));  // R6
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((status_q & $past(clr_mask) & ~$past(ev_pad)) == '0));  // R6
    AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |-> $stable(enable_q));  // R5

endmodule

// File: rtl/gpio_irq_combine.sv
// Folds enabled status into one interrupt, registers it, and routes it to the
// request line picked by the line select. Assumes line_sel < NUM_LINES.
module gpio_irq_combine #(
    parameter int NUM_PINS  = 64,
    parameter int NUM_LINES = 2,
    localparam int SEL_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  status,
    input  logic [NUM_PINS-1:0]  enable,
    input  logic [SEL_W-1:0]     line_sel,
    output logic [NUM_LINES-1:0] irq_out
);

    logic any_pending;
    logic irq_q;

    // OR of all enabled pending pins
    assign any_pending = |(status & enable);

    // One register stage on the combined interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= any_pending;
    end

    for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
        // Drive line j only when it is the selected one
        assign irq_out[j] = irq_q && (line_sel == SEL_W'(j));
    end

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_out));  // R10
    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((|irq_out) == $past(|(status & enable))));  // R9

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the GPIO interrupt block: event detection, bitmapped status/enable
// words, the line-select control word and the registered interrupt output.
// Assumes a single-cycle register write port and combinational reads.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] trig_level,
    input  logic [NUM_PINS-1:0] trig_inv,
    input  logic                reg_wr,
    input  logic [7:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [1:0]          irq_out
);

    localparam int NUM_LINES = 2;
    localparam int SEL_W     = $clog2(NUM_LINES);

    logic [NUM_PINS-1:0] pin_event;
    logic [NUM_PINS-1:0] status;
    logic [NUM_PINS-1:0] enable;
    logic [REG_W-1:0]    bank_rdata;
    logic [SEL_W-1:0]    line_sel_q;

    gpio_irq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_level  (pin_level),
        .trig_level (trig_level),
        .trig_inv   (trig_inv),
        .pin_event  (pin_event)
    );

    gpio_irq_status_bank #(.NUM_PINS(NUM_PINS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_event (pin_event),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .status    (status),
        .enable    (enable),
        .rdata     (bank_rdata)
    );

    // Line-select control word
    always_ff @(posedge clk) begin
        if (!rst_n)                             line_sel_q <= '0;
        else if (reg_wr && reg_addr == CTRL_ADDR) line_sel_q <= reg_wdata[SEL_W-1:0];
    end

    // Merge control read-back into the bank read data
    always_comb begin
        reg_rdata = bank_rdata;
        if (reg_addr == CTRL_ADDR) reg_rdata = REG_W'(line_sel_q);
    end

    gpio_irq_combine #(.NUM_PINS(NUM_PINS), .NUM_LINES(NUM_LINES)) u_combine (
        .clk      (clk),
        .rst_n    (rst_n),
        .status   (status),
        .enable   (enable),
        .line_sel (line_sel_q),
        .irq_out  (irq_out)
    );

    AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(reg_wr) && $past(reg_addr) == CTRL_ADDR)) |-> $stable(line_sel_q));  // R10

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;

    localparam int NP = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_level = '0;
    logic [NP-1:0] trig_level = '0;
    logic [NP-1:0] trig_inv = '0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_addr = 8'h00;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [1:0]    irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_irq_ctrl #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .trig_level(trig_level),
        .trig_inv(trig_inv), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // Reference model state
    logic [NP-1:0] m_status, m_enable, m_prev;
    logic          m_sel, m_irq;

    always @(posedge clk) begin
        logic [NP-1:0] ev;
        logic [63:0]   w;
        logic          nxt_irq;
        if (!rst_n) begin
            m_status = '0; m_enable = '0; m_sel = 0; m_irq = 0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                if (!trig_level[i]) ev[i] = trig_inv[i] ? (!pin_level[i] && m_prev[i])
                                                        : (pin_level[i] && !m_prev[i]);
                else                ev[i] = trig_inv[i] ? pin_level[i] : !pin_level[i];
            end
            nxt_irq = |(m_status & m_enable);
            w = {32'h0, m_status[31:0]} | ({24'h0, m_status[NP-1:32]} << 32);
            if (reg_wr && reg_addr == 8'h80) w[31:0]  = w[31:0]  & ~reg_wdata;
            if (reg_wr && reg_addr == 8'h84) w[63:32] = w[63:32] & ~reg_wdata;
            m_status = w[NP-1:0] | ev;
            w = 64'(m_enable);
            if (reg_wr && reg_addr == 8'h90) w[31:0]  = reg_wdata;
            if (reg_wr && reg_addr == 8'h94) w[63:32] = reg_wdata;
            m_enable = w[NP-1:0];
            if (reg_wr && reg_addr == 8'h7C) m_sel = reg_wdata[0];
            m_irq = nxt_irq;
        end
        m_prev = pin_level;
    end

    function automatic logic [31:0] mread(input logic [7:0] a);
        case (a)
            8'h7C:   return {31'h0, m_sel};
            8'h80:   return m_status[31:0];
            8'h84:   return {24'h0, m_status[NP-1:32]};
            8'h90:   return m_enable[31:0];
            8'h94:   return {24'h0, m_enable[NP-1:32]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare outputs against the model after every clock
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk("R9 R10 irq_out", 32'(irq_out), 32'(m_sel ? {m_irq, 1'b0} : {1'b0, m_irq}));
        chk("R5 rdata", reg_rdata, mread(reg_addr));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
        chk({req, " model"}, reg_rdata, mread(a));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        pin_level[5] = 1'b1;            // high through reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(); step();
        // R11 reset state, no edge from a pin high at reset (R1)
        rd("R11 status0", 8'h80, 32'h0);
        rd("R11 ctrl", 8'h7C, 32'h0);
        rd("R11 enable0", 8'h90, 32'h0);
        chk("R11 irq", 32'(irq_out), 32'h0);

        // R1 rising edge on pin 3
        pin_level[3] = 1; step();
        rd("R1 rise", 8'h80, 32'h8);
        pin_level[3] = 0; step();
        rd("R1 fall ignored", 8'h80, 32'h8);
        wr(8'h80, 32'h8);
        rd("R6 clear", 8'h80, 32'h0);

        // R2 falling edge on pin 36
        trig_inv[36] = 1; pin_level[36] = 1; step();
        rd("R2 rise ignored", 8'h84, 32'h0);
        pin_level[36] = 0; step();
        rd("R2 fall", 8'h84, 32'h10);

        // R6 write-0 keeps, write-1 clears
        wr(8'h84, 32'h0);
        rd("R6 zero write", 8'h84, 32'h10);
        wr(8'h84, 32'hFFFF_FFEF);
        rd("R6 other ones", 8'h84, 32'h10);
        wr(8'h84, 32'h10);
        rd("R6 clear word1", 8'h84, 32'h0);

        // R3 level low on pin 10
        trig_level[10] = 1; step();
        rd("R3 low sets", 8'h80, 32'h400);
        wr(8'h80, 32'h400);
        rd("R3 re-set while low", 8'h80, 32'h400);
        pin_level[10] = 1; step();
        wr(8'h80, 32'h400);
        rd("R3 high clears", 8'h80, 32'h0);

        // R4 level high on pin 11
        trig_level[11] = 1; trig_inv[11] = 1; step();
        rd("R4 low ignored", 8'h80, 32'h0);
        pin_level[11] = 1; step();
        rd("R4 high sets", 8'h80, 32'h800);
        pin_level[11] = 0;
        wr(8'h80, 32'h800);
        rd("R4 cleared", 8'h80, 32'h0);

        // R7 edge coincident with clear
        pin_level[3] = 1; step();
        pin_level[3] = 0; step();
        pin_level[3] = 1;
        wr(8'h80, 32'h8);
        rd("R7 event wins", 8'h80, 32'h8);
        wr(8'h80, 32'h8);
        rd("R7 later clear", 8'h80, 32'h0);

        // R8 status without enable, R9 latency, R10 routing
        pin_level[20] = 1; step(); step();
        rd("R8 latched", 8'h80, 32'h0010_0000);
        chk("R8 masked irq", 32'(irq_out), 32'h0);
        wr(8'h90, 32'h0010_0000);
        chk("R9 not yet", 32'(irq_out), 32'h0);
        step();
        chk("R9 line0", 32'(irq_out), 32'h1);
        wr(8'h7C, 32'h1);
        chk("R10 line1", 32'(irq_out), 32'h2);
        rd("R10 ctrl readback", 8'h7C, 32'h1);
        wr(8'h80, 32'h0010_0000);
        chk("R9 held one cycle", 32'(irq_out), 32'h2);
        step();
        chk("R9 drops", 32'(irq_out), 32'h0);
        wr(8'h7C, 32'hFFFF_FFFE);
        rd("R10 ctrl bit0", 8'h7C, 32'h0);

        // R5 map edges
        wr(8'h94, 32'hFFFF_FFFF);
        rd("R5 enable upper", 8'h94, 32'h0000_00FF);
        rd("R5 unmapped", 8'h40, 32'h0);
        rd("R5 beyond words", 8'h88, 32'h0);
        step();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule